// File: doc/BRIEF.md
# Address Decoder with Strap and Software Write Locks

This block sits between the address bus of an 8-bit processor and the devices on its 64 KB memory map. It drives an active-low select for a lower 32 KB memory, one for an upper 32 KB memory, and up to eight active-low peripheral selects. It also gates the shared active-low write strobe. Each peripheral select covers a 1 KB window at the start of an odd 4 KB page: slot k lives at `k*0x2000 + 0x1000`. A build-time mask chooses which slots are fitted. Memory is withheld from the whole 4 KB page of every fitted slot. With the default mask the only gap is 0x1000–0x1FFF.

Two nested write locks guard the upper memory. The boot lock covers the top 4 KB page, which holds the trap, interrupt and reset vectors. The wide lock covers all of 0x8000–0xFFFF. The boot lock is set only by a strap input. The wide lock is set by its own strap OR a control bit that software can write, so firmware can be uploaded first and then frozen. A write that a lock blocks reaches no device, and no write strobe is driven. The block raises a one-cycle violation pulse for it. The processor sees no difference.

Two small state machines hold the state. The lock machine has states `LK_OPEN` and `LK_LOCKED`. Its transitions are *arm* (OPEN→LOCKED when the control strobe writes 1) and *release* (LOCKED→OPEN when it writes 0). The violation machine has states `VI_IDLE`, `VI_FLAG` and `VI_HOLD`. Its transitions are:
- *detect*: IDLE→FLAG on a blocked cycle.
- *persist*: FLAG→HOLD, and HOLD→HOLD, while blocking continues.
- *clear*: FLAG or HOLD→IDLE on any unblocked cycle.

The pulse output is high only in `VI_FLAG`.

Top module: `memmap_decoder`

## Requirements
- R1: With `cyc_valid`=1, an address with bit 15 = 0 that is outside every fitted slot's 4 KB page drives `lo_cs_n`=0, in the same cycle.
- R2: With `cyc_valid`=1, an address with bit 15 = 1 that is outside any fitted slot's page drives `hi_cs_n`=0 for reads in every lock state. `lo_cs_n` and `hi_cs_n` are never low together.
- R3: `per_cs_n[k]` is low only for a fitted slot k (mask bit k = 1), at addresses whose bits 15:13 = k, bit 12 = 1 and bits 11:10 = 0. The remaining 3 KB of that page selects no device.
- R4: No memory select is driven anywhere in a fitted slot's 4 KB page. Peripheral writes are never blocked by a lock.
- R5: With `boot_strap`=1, a write to 0xF000–0xFFFF keeps `hi_cs_n` and `mem_we_n` high. Reads there, including the vector addresses 0xFFF0, 0xFFF8 and 0xFFFE, still select the upper memory.
- R6: With `upper_strap`=1, a write to any upper-memory address keeps `hi_cs_n` and `mem_we_n` high. Lower-memory writes are unaffected.
- R7: The lock register resets to open. A cycle with `ctl_we`=1 loads `ctl_wdata` at that clock edge. From the next cycle, a set bit blocks upper-memory writes exactly as `upper_strap` does.
- R8: With `cyc_valid`=0, all selects and `mem_we_n` are high, whatever the other inputs are.
- R9: `mem_we_n` is low exactly when `cyc_valid`=1, `rd_wn`=0, and some device select is low for that address.
- R10: `prot_viol` is high for exactly one cycle: the cycle after the first clock edge of a run of consecutive blocked writes. It stays low otherwise, and also after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address |
| rd_wn | input | 1 | 1 = read, 0 = write |
| cyc_valid | input | 1 | Address and direction are stable and valid |
| boot_strap | input | 1 | Lock writes to the top 4 KB page |
| upper_strap | input | 1 | Lock writes to the upper 32 KB |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 1 | Value loaded into the software lock bit |
| lo_cs_n | output | 1 | Lower memory select, active low |
| hi_cs_n | output | 1 | Upper memory select, active low |
| per_cs_n | output | 8 | Peripheral slot selects, active low |
| mem_we_n | output | 1 | Gated write strobe, active low |
| prot_viol | output | 1 | One-cycle pulse on a blocked write |

## Verification
The bench builds two copies side by side and drives both with the same inputs. The first uses the default mask 0x01, a single slot at 0x1000. The second uses mask 0x21, which adds slot 5 at 0xB000 inside the lockable upper half. That second copy shows that a fitted slot carves a gap out of upper memory. It also shows that writes into that gap pass while the wide lock is set and raise no violation. The unfitted slot at 0x3000 falls back to lower memory in both copies.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    typedef enum logic [0:0] {
        LK_OPEN   = 1'b0,
        LK_LOCKED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        VI_IDLE = 2'd0,
        VI_FLAG = 2'd1,
        VI_HOLD = 2'd2
    } viol_state_e;

    typedef struct packed {
        logic lo;    // lower memory owns the address
        logic hi;    // upper memory owns the address
        logic boot;  // address lies in the top boot page
    } region_t;

endpackage

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
    import memmap_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               NSLOT     = 8,
    parameter logic [NSLOT-1:0] SLOT_MASK = 8'h01,
    parameter int               WIN_W     = 2,
    parameter int               BOOT_W    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_t           region,
    output logic [NSLOT-1:0]  slot_hit
);
    localparam int SEL_W   = $clog2(NSLOT);
    localparam int ODD_BIT = ADDR_W - SEL_W - 1;

    logic [NSLOT-1:0] page_io;
    logic             hole;

    // one comparator per slot; the mask removes unfitted slots
    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        assign page_io[k]  = SLOT_MASK[k]
                           && (addr[ADDR_W-1 -: SEL_W] == SEL_W'(k))
                           && addr[ODD_BIT];
        assign slot_hit[k] = page_io[k] && (addr[ODD_BIT-1 -: WIN_W] == '0);
    end

    assign hole        = |page_io;
    assign region.lo   = !addr[ADDR_W-1] && !hole;
    assign region.hi   =  addr[ADDR_W-1] && !hole;
    assign region.boot = &addr[ADDR_W-1 -: BOOT_W];

endmodule

// File: rtl/mmd_lock_fsm.sv
module mmd_lock_fsm
    import memmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    output logic locked
);
    lock_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= LK_OPEN;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            LK_OPEN:   if (wr_en &&  wr_bit) st_nx = LK_LOCKED;  // arm
            LK_LOCKED: if (wr_en && !wr_bit) st_nx = LK_OPEN;    // release
            default:                         st_nx = LK_OPEN;
        endcase
    end

    assign locked = (st == LK_LOCKED);

    // R7: a write of 1 is visible on the next cycle
    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bit) |=> locked);
    // R7: a write of 0 releases on the next cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_bit) |=> !locked);
    // R7: without a strobe the bit holds
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(locked));

endmodule

// File: rtl/mmd_viol_fsm.sv
module mmd_viol_fsm
    import memmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blocked,
    output logic pulse
);
    viol_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= VI_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            VI_IDLE: if (blocked) st_nx = VI_FLAG;                 // detect
            VI_FLAG: st_nx = blocked ? VI_HOLD : VI_IDLE;          // persist / clear
            VI_HOLD: if (!blocked) st_nx = VI_IDLE;                // clear
            default: st_nx = VI_IDLE;
        endcase
    end

    assign pulse = (st == VI_FLAG);

    // R10: never two pulse cycles in a row
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
    // R10: a pulse is always caused by a blocked edge
    a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(blocked));

endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
    import memmap_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter int               NSLOT     = 8,
    parameter logic [NSLOT-1:0] SLOT_MASK = 8'h01,
    parameter int               WIN_W     = 2,
    parameter int               BOOT_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wn,
    input  logic              cyc_valid,
    input  logic              boot_strap,
    input  logic              upper_strap,
    input  logic              ctl_we,
    input  logic              ctl_wdata,
    output logic              lo_cs_n,
    output logic              hi_cs_n,
    output logic [NSLOT-1:0]  per_cs_n,
    output logic              mem_we_n,
    output logic              prot_viol
);
    region_t          region;
    logic [NSLOT-1:0] slot_hit;
    logic             sw_lock;
    logic             wr_cyc;
    logic             prot_hit;
    logic             blocked;

    mmd_region_decode #(
        .ADDR_W(ADDR_W), .NSLOT(NSLOT), .SLOT_MASK(SLOT_MASK),
        .WIN_W(WIN_W), .BOOT_W(BOOT_W)
    ) u_decode (
        .addr(addr), .region(region), .slot_hit(slot_hit)
    );

    mmd_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_bit(ctl_wdata),
        .locked(sw_lock)
    );

    assign wr_cyc   = cyc_valid && !rd_wn;
    assign prot_hit = region.hi && ((boot_strap && region.boot) || upper_strap || sw_lock);
    assign blocked  = wr_cyc && prot_hit;

    mmd_viol_fsm u_viol (
        .clk(clk), .rst_n(rst_n), .blocked(blocked), .pulse(prot_viol)
    );

    always_comb begin
        lo_cs_n  = !(cyc_valid && region.lo);
        hi_cs_n  = !(cyc_valid && region.hi && !blocked);
        per_cs_n = ~({NSLOT{cyc_valid}} & slot_hit);
        mem_we_n = !(wr_cyc && !blocked && (region.lo || region.hi || |slot_hit));
    end

    // R8: an invalid cycle leaves every strobe idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> (lo_cs_n && hi_cs_n && (&per_cs_n) && mem_we_n));
    // R2: the two memories are never selected together
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!lo_cs_n && !hi_cs_n));
    // R3: at most one peripheral slot at a time
    a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~per_cs_n));
    // R4: a peripheral select excludes both memories
    a_r4_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (~per_cs_n != '0) |-> (lo_cs_n && hi_cs_n));
    // R5: boot page writes never strobe with the strap set
    a_r5_boot_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_strap && !rd_wn && (&addr[ADDR_W-1 -: BOOT_W])) |-> (mem_we_n && hi_cs_n));
    // R6: upper writes never reach the upper memory with the strap set
    a_r6_upper_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_strap && !rd_wn) |-> hi_cs_n);
    // R9: the write strobe needs a selected device
    a_r9_we_has_target: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!lo_cs_n || !hi_cs_n || (~per_cs_n != '0)));

endmodule

// File: tb/test_memmap_decoder.sv
`timescale 1ns/1ps
module test_memmap_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd_wn = 1'b1;
    logic        cyc_valid = 1'b0;
    logic        boot_strap = 1'b0;
    logic        upper_strap = 1'b0;
    logic        ctl_we = 1'b0;
    logic        ctl_wdata = 1'b0;

    logic       lo_a, hi_a, we_a, vi_a, lo_b, hi_b, we_b, vi_b;
    logic [7:0] per_a, per_b;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;  // 250 MHz

    memmap_decoder #(.SLOT_MASK(8'h01)) i_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wn(rd_wn), .cyc_valid(cyc_valid),
        .boot_strap(boot_strap), .upper_strap(upper_strap), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .lo_cs_n(lo_a), .hi_cs_n(hi_a), .per_cs_n(per_a),
        .mem_we_n(we_a), .prot_viol(vi_a));

    memmap_decoder #(.SLOT_MASK(8'h21)) i_memmap_decoder_hi (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_wn(rd_wn), .cyc_valid(cyc_valid),
        .boot_strap(boot_strap), .upper_strap(upper_strap), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .lo_cs_n(lo_b), .hi_cs_n(hi_b), .per_cs_n(per_b),
        .mem_we_n(we_b), .prot_viol(vi_b));

    // reference model state
    logic [7:0] masks [2] = '{8'h01, 8'h21};
    bit m_lock = 1'b0;
    bit m_prev [2] = '{1'b0, 1'b0};
    bit m_viol [2] = '{1'b0, 1'b0};

    function automatic bit io_page(int i);
        int a = int'(addr);
        int page = a / 4096;
        return (page % 2 == 1) && masks[i][page / 2];
    endfunction

    function automatic bit model_blocked(int i);
        int a = int'(addr);
        bit hi_sel = (a >= 32768) && !io_page(i);
        bit prot = hi_sel && ((boot_strap && a >= 61440) || upper_strap || m_lock);
        return cyc_valid && !rd_wn && prot;
    endfunction

    // {lo, hi, per[7:0], we, viol}
    function automatic logic [11:0] model_out(int i);
        int a = int'(addr);
        int page = a / 4096;
        bit lo_sel = (a < 32768) && !io_page(i);
        bit hi_sel = (a >= 32768) && !io_page(i);
        bit blk = model_blocked(i);
        logic [7:0] per = 8'hFF;
        bit any;
        if (cyc_valid && io_page(i) && (a % 4096) < 1024) per[page / 2] = 1'b0;
        lo_sel = lo_sel && cyc_valid;
        hi_sel = hi_sel && cyc_valid && !blk;
        any = lo_sel || hi_sel || (per != 8'hFF);
        return {!lo_sel, !hi_sel, per, !(cyc_valid && !rd_wn && any), m_viol[i]};
    endfunction

    task automatic check_inst(int i, string req, logic [11:0] act);
        logic [11:0] exp = model_out(i);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s inst%0d addr=%h rw=%b v=%b: actual lo,hi,per,we,viol=%b expected %b",
                     req, i, addr, rd_wn, cyc_valid, act, exp);
        end
    endtask

    task automatic apply(string req, logic [15:0] a, logic rw, logic v,
                         logic bs, logic us, logic cwe, logic cwd);
        addr = a; rd_wn = rw; cyc_valid = v; boot_strap = bs; upper_strap = us;
        ctl_we = cwe; ctl_wdata = cwd;
        @(negedge clk);
        check_inst(0, req, {lo_a, hi_a, per_a, we_a, vi_a});
        check_inst(1, req, {lo_b, hi_b, per_b, we_b, vi_b});
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            bit blk = model_blocked(i);
            m_viol[i] = blk && !m_prev[i];
            m_prev[i] = blk;
        end
        if (cwe) m_lock = cwd;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R10 watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R8 reset state and idle cycles
        apply("R8", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R8", 16'hF000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R1 lower memory reads and writes
        apply("R1", 16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R1", 16'h0FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R1", 16'h2000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R1", 16'h7FFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R3 R4 peripheral slots and the page gaps
        apply("R3", 16'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R3", 16'h13FF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R4", 16'h1400, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R4", 16'h1FFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R3", 16'h3000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R3", 16'hB000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R4", 16'hB7FF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R2 R9 upper memory unlocked (reset state open: R7)
        apply("R2", 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R9", 16'hFFFE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R7", 16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 boot lock: run of blocked writes gives one pulse (R10)
        apply("R5", 16'hF000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5", 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R10", 16'hFFF0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R10", 16'hFFFE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5", 16'hFFF8, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R5", 16'hEFFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R10", 16'hF800, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R10", 16'h0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        apply("R10", 16'h0100, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // R6 wide strap; gap at 0xB000 stays writable on the second copy
        apply("R6", 16'h8000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        apply("R6", 16'hB000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        apply("R6", 16'h7FFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        apply("R6", 16'hC000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R7 software lock: arm, block, release
        apply("R7", 16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        apply("R7", 16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R7", 16'hA000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R7", 16'h4000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        apply("R7", 16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        apply("R7", 16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R8 invalid cycle over a protected write
        apply("R8", 16'hFFFE, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply("R8", 16'h1000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // sweep of every 1 KB block, read and write (R1 R2 R3 R9)
        for (int blk = 0; blk < 64; blk++) begin
            apply("R9", 16'(blk * 1024 + 5), 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
            apply("R3", 16'(blk * 1024 + 5), 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule